// File: doc/BRIEF.md
# PHY Control Register Bank with Per-Bit Write Masks

This block holds the static control settings of a serial camera receiver PHY. It has four 32-bit control registers and one read-only status register, all on a simple word-addressed write and read port. Every write word carries its own mask. The lower half holds the new bit values. The upper half has one enable bit per lower bit, sixteen positions above that bit. A driver can therefore change one field, such as the force-stop nibble or the test clock pin, in a single write, with no read-modify-write cycle and no risk of clobbering a neighbouring field.

The register contents drive the PHY pins directly:
- per-lane enable nibble
- force-receive nibble
- force-stop nibble
- turn-disable nibble
- turn-request nibble
- source select, base direction, clock enable and master/slave select bits
- the test-port data, enable, clock and clear pins
- two clock-invert selects

The status register returns the PHY's 8-bit test data output. Unmapped write addresses are reported with a one-cycle error pulse.

Word map (index on `wr_addr` / `rd_addr`):
- 0 lane control
- 1 turnaround/mode
- 2 test port
- 3 clock invert
- 4 status (read-only)
- 5 and above unmapped

Top module: `phy_ctl_bank`

## Requirements
- R1: While `rst_n` is low and after its release, all control fields, `rd_data` and `wr_err` are zero until the first write or read.
- R2: On a write to a control register, each implemented bit i of bits 15:0 takes `wr_data[i]` at the clock edge if `wr_data[i+16]` is 1. The new value is visible on the outputs in the cycle after that edge.
- R3: On a write, every low bit whose mask bit (i+16) is 0 keeps its previous value.
- R4: Word 0 maps to the PHY pins as follows: bits 3:0 drive `lane_enable`, 7:4 drive `force_rx`, 11:8 drive `force_stop` and 15:12 drive `turn_disable`.
- R5: Word 2 maps to the test port as follows: bits 7:0 drive `test_din`, bit 8 drives `test_en`, bit 9 drives `test_clk` and bit 10 drives `test_clr`.
- R6: Word 1 maps as follows: bits 3:0 drive `turn_request`, bit 4 drives `src_sel`, bit 5 drives `base_dir`, bit 6 drives `clk_enable` and bit 7 drives `master_sel`.
- R7: Word 3 bit 0 drives `clk_inv[0]` and bit 1 drives `clk_inv[1]`.
- R8: A read of word 0–3 returns the stored low 16 bits on `rd_data` in the cycle after `rd_en`. Unimplemented bits read as zero: word 1 bits 15:8, word 2 bits 15:11 and word 3 bits 15:2. Bits 31:16 always read as zero.
- R9: A read of word 4 returns `test_dout` as sampled at the read edge in bits 7:0, with all other bits zero. A write to word 4 changes nothing and raises no error.
- R10: A write to a word above 4 changes no register and sets `wr_err` high for exactly the one cycle after the write edge. A read of such a word returns zero.
- R11: A read issued in the same cycle as a write to the same word returns the value from before the write.
- R12: While `rd_en` is low, `rd_data` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write request |
| wr_addr | input | ADDR_W | Write word index |
| wr_data | input | 32 | Bits 15:0 value, bits 31:16 per-bit enable |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word index |
| rd_data | output | 32 | Registered read data |
| wr_err | output | 1 | One-cycle pulse after a write to an unmapped word |
| test_dout | input | 8 | PHY test data output, shown in the status word |
| lane_enable | output | 4 | Per-lane enable |
| force_rx | output | 4 | Per-lane force-receive mode |
| force_stop | output | 4 | Per-lane force-stop mode |
| turn_disable | output | 4 | Per-lane turnaround disable |
| turn_request | output | 4 | Per-lane turnaround request |
| src_sel | output | 1 | Second-port source select |
| base_dir | output | 1 | Base direction |
| clk_enable | output | 1 | Clock lane enable |
| master_sel | output | 1 | Master (1) / slave (0) select |
| test_din | output | 8 | Test port data in |
| test_en | output | 1 | Test port enable (1 = code phase) |
| test_clk | output | 1 | Test port clock |
| test_clr | output | 1 | Test port clear |
| clk_inv | output | 2 | Clock-invert selects |

## Verification
Three results are due one rising edge after their stimulus:
- a masked write shows on the field pins;
- a read shows on `rd_data`;
- a write to an unmapped word shows as `wr_err`, which then drops one edge later.

The bench drives each operation on a falling edge and computes the expected pins, read word and error flag from a software copy of the registers, taken before that operation's write is applied. It compares them on the next falling edge, so a same-cycle read sees the old contents as required. Hold behaviour is checked by idle steps that change `test_dout` without a read.

// File: rtl/phyc_pkg.sv
package phyc_pkg;

  localparam int HALF_W   = 16;
  localparam int DATA_W   = 2 * HALF_W;
  localparam int NUM_CTRL = 4;
  localparam int STAT_IDX = NUM_CTRL;
  localparam int LANES    = 4;
  localparam int TEST_W   = 8;
  localparam int CINV_W   = 2;

  typedef enum logic [2:0] {
    IDX_LANE = 3'd0,
    IDX_TURN = 3'd1,
    IDX_TEST = 3'd2,
    IDX_CINV = 3'd3,
    IDX_STAT = 3'd4
  } reg_idx_e;

  typedef struct packed {
    logic [LANES-1:0] turn_dis;
    logic [LANES-1:0] force_stop;
    logic [LANES-1:0] force_rx;
    logic [LANES-1:0] lane_en;
  } lane_ctrl_t;

  typedef struct packed {
    logic             master;
    logic             clk_en;
    logic             base_dir;
    logic             src_sel;
    logic [LANES-1:0] turn_req;
  } turn_ctrl_t;

  typedef struct packed {
    logic              clr;
    logic              tck;
    logic              ten;
    logic [TEST_W-1:0] din;
  } test_ctrl_t;

  function automatic logic [HALF_W-1:0] impl_bits(input int idx);
    logic [HALF_W-1:0] m;
    case (idx)
      0:       m = HALF_W'((1 << $bits(lane_ctrl_t)) - 1);
      1:       m = HALF_W'((1 << $bits(turn_ctrl_t)) - 1);
      2:       m = HALF_W'((1 << $bits(test_ctrl_t)) - 1);
      3:       m = HALF_W'((1 << CINV_W) - 1);
      default: m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/phyc_wdec.sv
module phyc_wdec #(
  parameter int ADDR_W   = 3,
  parameter int NUM_CTRL = 4
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic [NUM_CTRL-1:0] sel,
  output logic              bad
);

  localparam int LAST_MAPPED = NUM_CTRL;

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_sel
    assign sel[i] = wr_en && (int'(wr_addr) == i);
  end

  assign bad = wr_en && (int'(wr_addr) > LAST_MAPPED);

endmodule

// File: rtl/phyc_mreg.sv
module phyc_mreg #(
  parameter int              HALF_W = 16,
  parameter logic [HALF_W-1:0] IMPL = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_sel,
  input  logic [HALF_W-1:0] wr_val,
  input  logic [HALF_W-1:0] wr_msk,
  output logic [HALF_W-1:0] q
);

  logic [HALF_W-1:0] eff_msk;
  logic [HALF_W-1:0] q_d;

  always_comb begin
    eff_msk = wr_msk & IMPL;
    q_d     = (q & ~eff_msk) | (wr_val & eff_msk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (wr_sel) begin
      q <= q_d;
    end
  end

endmodule

// File: rtl/phyc_rdmux.sv
module phyc_rdmux #(
  parameter int ADDR_W   = 3,
  parameter int NUM_CTRL = 4,
  parameter int HALF_W   = 16,
  parameter int DATA_W   = 32,
  parameter int STAT_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [NUM_CTRL*HALF_W-1:0] ctrl_flat,
  input  logic [STAT_W-1:0]          status,
  output logic [DATA_W-1:0]          rd_data
);

  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_CTRL; i++) begin
      if (int'(rd_addr) == i) begin
        rd_d[HALF_W-1:0] = ctrl_flat[i*HALF_W +: HALF_W];
      end
    end
    if (int'(rd_addr) == NUM_CTRL) begin
      rd_d[STAT_W-1:0] = status;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= rd_d;
    end
  end

endmodule

// File: rtl/phy_ctl_bank.sv
module phy_ctl_bank
  import phyc_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              wr_err,
  input  logic [7:0]        test_dout,
  output logic [3:0]        lane_enable,
  output logic [3:0]        force_rx,
  output logic [3:0]        force_stop,
  output logic [3:0]        turn_disable,
  output logic [3:0]        turn_request,
  output logic              src_sel,
  output logic              base_dir,
  output logic              clk_enable,
  output logic              master_sel,
  output logic [7:0]        test_din,
  output logic              test_en,
  output logic              test_clk,
  output logic              test_clr,
  output logic [1:0]        clk_inv
);

  logic [NUM_CTRL-1:0]        wsel;
  logic                       wbad;
  logic                       err_d;
  logic [NUM_CTRL*HALF_W-1:0] ctrl_flat;

  phyc_wdec #(
    .ADDR_W  (ADDR_W),
    .NUM_CTRL(NUM_CTRL)
  ) u_wdec (
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .sel    (wsel),
    .bad    (wbad)
  );

  for (genvar r = 0; r < NUM_CTRL; r++) begin : g_reg
    phyc_mreg #(
      .HALF_W(HALF_W),
      .IMPL  (impl_bits(r))
    ) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_sel(wsel[r]),
      .wr_val(wr_data[HALF_W-1:0]),
      .wr_msk(wr_data[DATA_W-1:HALF_W]),
      .q     (ctrl_flat[r*HALF_W +: HALF_W])
    );
  end

  phyc_rdmux #(
    .ADDR_W  (ADDR_W),
    .NUM_CTRL(NUM_CTRL),
    .HALF_W  (HALF_W),
    .DATA_W  (DATA_W),
    .STAT_W  (TEST_W)
  ) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .ctrl_flat(ctrl_flat),
    .status   (test_dout),
    .rd_data  (rd_data)
  );

  always_comb begin
    err_d = wbad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_err <= 1'b0;
    end else begin
      wr_err <= err_d;
    end
  end

  lane_ctrl_t lane_s;
  turn_ctrl_t turn_s;
  test_ctrl_t test_s;

  always_comb begin
    lane_s = lane_ctrl_t'(ctrl_flat[IDX_LANE*HALF_W +: $bits(lane_ctrl_t)]);
    turn_s = turn_ctrl_t'(ctrl_flat[IDX_TURN*HALF_W +: $bits(turn_ctrl_t)]);
    test_s = test_ctrl_t'(ctrl_flat[IDX_TEST*HALF_W +: $bits(test_ctrl_t)]);
  end

  assign lane_enable  = lane_s.lane_en;
  assign force_rx     = lane_s.force_rx;
  assign force_stop   = lane_s.force_stop;
  assign turn_disable = lane_s.turn_dis;
  assign turn_request = turn_s.turn_req;
  assign src_sel      = turn_s.src_sel;
  assign base_dir     = turn_s.base_dir;
  assign clk_enable   = turn_s.clk_en;
  assign master_sel   = turn_s.master;
  assign test_din     = test_s.din;
  assign test_en      = test_s.ten;
  assign test_clk     = test_s.tck;
  assign test_clr     = test_s.clr;
  assign clk_inv      = ctrl_flat[IDX_CINV*HALF_W +: CINV_W];

endmodule

// File: rtl/phyc_chk.sv
module phyc_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic              wr_err,
  input logic [7:0]        test_dout,
  input logic [15:0]       lane_bus,
  input logic [7:0]        turn_bus,
  input logic [10:0]       test_bus,
  input logic [1:0]        cinv_bus
);

  localparam logic [ADDR_W-1:0] A_LANE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(4);

  logic lane_wr;
  logic ctrl_wr;
  logic bad_wr;
  assign lane_wr = wr_en && (wr_addr == A_LANE);
  assign ctrl_wr = wr_en && (wr_addr < A_STAT);
  assign bad_wr  = wr_en && (wr_addr > A_STAT);

  AST_MASKED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    lane_wr |=> ((lane_bus & $past(wr_data[31:16])) ==
                 ($past(wr_data[15:0]) & $past(wr_data[31:16])))); // R2

  AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    lane_wr |=> (((lane_bus ^ $past(lane_bus)) & ~$past(wr_data[31:16])) == 16'h0)); // R3

  AST_LANE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !lane_wr |=> $stable(lane_bus)); // R4

  AST_NO_CTRL_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> ($stable(turn_bus) && $stable(test_bus) && $stable(cinv_bus))); // R9

  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> wr_err); // R10

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(bad_wr)); // R10

  AST_STATUS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_STAT) |=> (rd_data == {24'h0, $past(test_dout)})); // R9

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[31:16] == 16'h0); // R8

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R12

endmodule

bind phy_ctl_bank phyc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .rd_en    (rd_en),
  .rd_addr  (rd_addr),
  .rd_data  (rd_data),
  .wr_err   (wr_err),
  .test_dout(test_dout),
  .lane_bus ({turn_disable, force_stop, force_rx, lane_enable}),
  .turn_bus ({master_sel, clk_enable, base_dir, src_sel, turn_request}),
  .test_bus ({test_clr, test_clk, test_en, test_din}),
  .cinv_bus (clk_inv)
);

// File: tb/sim_phy_ctl_bank.sv
`timescale 1ns/1ps
module sim_phy_ctl_bank;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_addr;
  logic [31:0] wr_data;
  logic        rd_en;
  logic [2:0]  rd_addr;
  logic [31:0] rd_data;
  logic        wr_err;
  logic [7:0]  test_dout;
  logic [3:0]  lane_enable, force_rx, force_stop, turn_disable, turn_request;
  logic        src_sel, base_dir, clk_enable, master_sel;
  logic [7:0]  test_din;
  logic        test_en, test_clk, test_clr;
  logic [1:0]  clk_inv;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [15:0] mdl [4];
  logic [31:0] exp_rd;
  logic        exp_err;

  phy_ctl_bank #(.ADDR_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_err(wr_err),
    .test_dout(test_dout), .lane_enable(lane_enable), .force_rx(force_rx),
    .force_stop(force_stop), .turn_disable(turn_disable), .turn_request(turn_request),
    .src_sel(src_sel), .base_dir(base_dir), .clk_enable(clk_enable),
    .master_sel(master_sel), .test_din(test_din), .test_en(test_en),
    .test_clk(test_clk), .test_clr(test_clr), .clk_inv(clk_inv)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] impl_of(input int idx);
    case (idx)
      0: return 16'hFFFF;
      1: return 16'h00FF;
      2: return 16'h07FF;
      3: return 16'h0003;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [31:0] model_read(input logic [2:0] a, input logic [7:0] td);
    if (a < 3'd4) return {16'h0, mdl[a]};
    if (a == 3'd4) return {24'h0, td};
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic check_pins();
    chk("R4 lane word", {16'h0, turn_disable, force_stop, force_rx, lane_enable}, {16'h0, mdl[0]});
    chk("R6 turn word", {24'h0, master_sel, clk_enable, base_dir, src_sel, turn_request}, {24'h0, mdl[1][7:0]});
    chk("R5 test word", {21'h0, test_clr, test_clk, test_en, test_din}, {21'h0, mdl[2][10:0]});
    chk("R7 clk inv", {30'h0, clk_inv}, {30'h0, mdl[3][1:0]});
    chk("R8 read data", rd_data, exp_rd);
    chk("R10 err flag", {31'h0, wr_err}, {31'h0, exp_err});
  endtask

  // called at a falling edge; checks at the next falling edge
  task automatic step(input logic we, input logic [2:0] wa, input logic [31:0] wd,
                      input logic re, input logic [2:0] ra, input logic [7:0] td);
    logic [15:0] m;
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra; test_dout = td;
    if (re) exp_rd = model_read(ra, td);
    exp_err = we && (wa > 3'd4);
    if (we && wa < 3'd4) begin
      m = wd[31:16] & impl_of(int'(wa));
      mdl[wa] = (mdl[wa] & ~m) | (wd[15:0] & m);
    end
    @(posedge clk);
    @(negedge clk);
    check_pins();
  endtask

  task automatic idle(input logic [7:0] td);
    step(1'b0, 3'd0, 32'h0, 1'b0, 3'd0, td);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] old;
    clk = 0; rst_n = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_en = 0; rd_addr = 0; test_dout = 0;
    for (int i = 0; i < 4; i++) mdl[i] = 16'h0;
    exp_rd = 0; exp_err = 0;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    // R1: reset state while held
    @(negedge clk);
    check_pins();
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset state", {16'h0, turn_disable, force_stop, force_rx, lane_enable}, 32'h0);
    chk("R1 reset rd", rd_data, 32'h0);

    // R2 masked update of force-receive nibble only
    step(1'b1, 3'd0, 32'h00F0_ABCD, 1'b0, 3'd0, 8'h00);
    chk("R2 force_rx set", {28'h0, force_rx}, 32'hC);
    chk("R3 others kept", {20'h0, turn_disable, force_stop, lane_enable}, 32'h0);
    step(1'b1, 3'd0, 32'h000F_1235, 1'b0, 3'd0, 8'h00);
    chk("R3 force_rx kept", {28'h0, force_rx}, 32'hC);
    chk("R2 lane set", {28'h0, lane_enable}, 32'h5);

    // R9 write to status ignored, no error
    step(1'b1, 3'd4, 32'hFFFF_FFFF, 1'b0, 3'd0, 8'h00);
    chk("R9 no err", {31'h0, wr_err}, 32'h0);

    // R10 unmapped write pulse
    step(1'b1, 3'd6, 32'hFFFF_FFFF, 1'b0, 3'd0, 8'h00);
    chk("R10 err high", {31'h0, wr_err}, 32'h1);
    idle(8'h00);
    chk("R10 err drops", {31'h0, wr_err}, 32'h0);

    // R11 read same cycle as write
    old = {16'h0, mdl[1]};
    step(1'b1, 3'd1, 32'hFFFF_00A5, 1'b1, 3'd1, 8'h00);
    chk("R11 old value", rd_data, old);
    step(1'b0, 3'd0, 32'h0, 1'b1, 3'd1, 8'h00);
    chk("R6 readback", rd_data, 32'h0000_00A5);

    // R8 unimplemented bits
    step(1'b1, 3'd2, 32'hFFFF_FFFF, 1'b0, 3'd0, 8'h00);
    step(1'b0, 3'd0, 32'h0, 1'b1, 3'd2, 8'h00);
    chk("R8 impl mask", rd_data, 32'h0000_07FF);

    // R9 status read
    step(1'b0, 3'd0, 32'h0, 1'b1, 3'd4, 8'h5A);
    chk("R9 status", rd_data, 32'h0000_005A);
    // R12 hold
    idle(8'hC3);
    chk("R12 hold", rd_data, 32'h0000_005A);

    // R7 clock invert, unmapped read
    step(1'b1, 3'd3, 32'h0003_0002, 1'b1, 3'd7, 8'h00);
    chk("R7 inv", {30'h0, clk_inv}, 32'h2);
    chk("R10 unmapped read", rd_data, 32'h0);

    for (int n = 0; n < 600; n++) begin
      step(1'($urandom), 3'($urandom), $urandom, 1'($urandom), 3'($urandom), 8'($urandom));
    end
    wr_en = 0; rd_en = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule